// File: doc/BRIEF.md
# Line-Rate Successive-Approximation Converter Sequencer

This block is the digital side of a 6-bit successive-approximation converter that digitises one held video level per scan line. A line pulse starts a conversion. The block drives a trial code to an external DAC, reads one comparator bit on each ADC clock tick, and resolves the code from the most significant bit down. Code 0x00 stands for an all-black line and 0x3F for an all-white line. A white-peak flag (a level above 50 IRE was present on the line) is latched by the same line pulse and is kept together with its result.

The finished 6-bit result and its peak flag form a 7-bit word. The next line pulse sends that word out serially, so each line's data appears one line period after the line was measured. A strobe marks the first bit. If a line pulse arrives before a conversion has finished, the block abandons that conversion and starts again. The abandoned conversion produces no word.

Top module: `sar_line_sequencer`

## Requirements
- R1: In reset (synchronous, active-low) and right after it, dac_code is 0, ser_data is 0 and word_valid is 0.
- R2: In the cycle after a line_pulse, dac_code is 6'b100000, the mid-scale trial.
- R3: On each adc_tick during a conversion, the bit under trial stays set if cmp_ge is 1 and is cleared if cmp_ge is 0. The next lower bit is then set. After six ticks, dac_code equals the largest code that is not above the input level.
- R4: A completed result stays on dac_code, whatever adc_tick and cmp_ge do, until the next line_pulse. dac_code never changes in a cycle with no line_pulse and no adc_tick.
- R5: The peak flag in the word is the value of peak_hit in the line_pulse cycle that started the conversion. Later changes of peak_hit have no effect on it.
- R6: A line_pulse sends out the word of the last completed conversion. word_valid is high for exactly the one cycle after that line_pulse, and ser_data then shows the peak bit. word_valid is never high unless line_pulse was high in the cycle before.
- R7: The word is sent as the peak bit first, then result bits 5 down to 0. Each adc_tick moves to the next bit. After the seventh tick, ser_data returns to 0. ser_data never changes in a cycle with no line_pulse and no adc_tick.
- R8: A line_pulse during an unfinished conversion restarts it at 6'b100000. The abandoned conversion yields no word: the line_pulse that follows gives no word_valid and leaves ser_data at 0.
- R9: A level of 0 converts to 0x00 and a level of 63 converts to 0x3F.
- R10: A line_pulse while a word is still being shifted cuts that word off. It then loads the new pending word, or, if there is none, drives ser_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pulse | input | 1 | One-cycle line-start strobe: samples peak flag, starts conversion, releases previous word |
| adc_tick | input | 1 | One-cycle enable marking an ADC clock step |
| cmp_ge | input | 1 | Comparator result, 1 when held level >= DAC output |
| peak_hit | input | 1 | White-peak comparator flag for the current line |
| dac_code | output | 6 | Trial/result code to the external DAC |
| ser_data | output | 1 | Serial word output, peak bit first then result MSB to LSB |
| word_valid | output | 1 | One-cycle strobe accompanying the first serial bit |

## Verification
The assertions check the following on every cycle: the mid-scale start after a line pulse, that the code and the serial line hold still when neither strobe is present, that a tick moves at most two code bits, and that the word strobe only follows a line pulse. Only the bench scenarios can show the values themselves. These are the converted result for a given level (including both end codes), the bit order of the serial word, the peak flag staying tied to its own line, and the dropped word after an aborted conversion. The bench compares every output on every cycle against a behavioural model.

// File: rtl/sar_seq_pkg.sv
// Package: shared types for the line-rate SAR sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_seq_pkg;
    typedef enum logic {
        CONV_IDLE = 1'b0,
        CONV_RUN  = 1'b1
    } conv_state_e;
endpackage

// File: rtl/sar_stepper.sv
// Module: sar_stepper
// Runs the successive-approximation search. It starts at mid-scale on
// start and resolves one bit per step, MSB first. It exposes the
// combinational next code and a finish strobe, so a downstream holder
// can capture the result on the same edge at which the code settles.
// Assumes: start and step are single-cycle strobes in the clk domain,
// and start takes priority over step.
module sar_stepper #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic              cmp_ge,
    output logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] code_nx,
    output logic              fin
);
    import sar_seq_pkg::*;

    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    conv_state_e      state;
    logic [IDX_W-1:0] idx;
    logic             advance;

    // Purpose: an active step is one that arrives while running and without a restart.
    assign advance = step && !start && (state == CONV_RUN);

    // Purpose: last step of the search, when the trial bit index is zero.
    assign fin = advance && (idx == '0);

    // Purpose: compute the next trial code (decide the current bit, set the next one).
    always_comb begin
        code_nx = code;
        if (!cmp_ge) begin
            code_nx[idx] = 1'b0;
        end
        if (idx != '0) begin
            code_nx[idx - IDX_W'(1)] = 1'b1;
        end
    end

    // Purpose: sequence state, bit index and code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CONV_IDLE;
            idx   <= '0;
            code  <= '0;
        end else if (start) begin
            state <= CONV_RUN;
            idx   <= IDX_W'(CODE_W - 1);
            code  <= MID;
        end else if (advance) begin
            code <= code_nx;
            if (idx == '0) begin
                state <= CONV_IDLE;
            end else begin
                idx <= idx - IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/line_word_buffer.sv
// Module: line_word_buffer
// Latches the peak flag at line start and assembles {peak, result} when a
// conversion finishes. It holds that word until the next line start
// releases it, which gives the one-line delay.
// Assumes: fin and start never coincide, since the stepper masks fin on start.
module line_word_buffer #(
    parameter int CODE_W = 6,
    parameter int WORD_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              peak_in,
    input  logic              fin,
    input  logic [CODE_W-1:0] result,
    output logic              load_en,
    output logic [WORD_W-1:0] load_word
);
    logic              peak_cap;
    logic              pend;
    logic [WORD_W-1:0] hold;

    // Purpose: release the pending word to the serializer on a line start.
    assign load_en   = start && pend;
    assign load_word = hold;

    // Purpose: capture the peak flag, build the finished word and track that it is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_cap <= 1'b0;
            pend     <= 1'b0;
            hold     <= '0;
        end else if (start) begin
            peak_cap <= peak_in;
            pend     <= 1'b0;
        end else if (fin) begin
            hold <= {peak_cap, result};
            pend <= 1'b1;
        end
    end
endmodule

// File: rtl/word_serializer.sv
// Module: word_serializer
// Shifts a word out MSB first, one bit per step. The first bit is marked
// with a one-cycle valid strobe. A start always ends the word in progress.
// Assumes: load_en can only be high together with start.
module word_serializer #(
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    input  logic              step,
    output logic              ser_data,
    output logic              word_valid
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  left;

    // Purpose: present the current top bit while bits remain, else 0.
    assign ser_data = (left != '0) ? sh[WORD_W-1] : 1'b0;

    // Purpose: load, shift and count the serial word; pulse valid with the first bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            left       <= '0;
            word_valid <= 1'b0;
        end else if (start) begin
            word_valid <= load_en;
            if (load_en) begin
                sh   <= load_word;
                left <= CNT_W'(WORD_W);
            end else begin
                left <= '0;
            end
        end else begin
            word_valid <= 1'b0;
            if (step && (left != '0)) begin
                sh   <= {sh[WORD_W-2:0], 1'b0};
                left <= left - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sar_line_sequencer.sv
// Module: sar_line_sequencer (top)
// Per-line SAR converter controller: search stepper, one-line word buffer
// and serial output stage.
// Assumes: line_pulse and adc_tick are synchronous single-cycle strobes,
// and the external comparator settles between ticks.
module sar_line_sequencer #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_pulse,
    input  logic              adc_tick,
    input  logic              cmp_ge,
    input  logic              peak_hit,
    output logic [CODE_W-1:0] dac_code,
    output logic              ser_data,
    output logic              word_valid
);
    localparam int WORD_W = CODE_W + 1;

    logic [CODE_W-1:0] code_nx;
    logic              fin;
    logic              load_en;
    logic [WORD_W-1:0] load_word;

    sar_stepper #(.CODE_W(CODE_W)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (line_pulse),
        .step    (adc_tick),
        .cmp_ge  (cmp_ge),
        .code    (dac_code),
        .code_nx (code_nx),
        .fin     (fin)
    );

    line_word_buffer #(.CODE_W(CODE_W), .WORD_W(WORD_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (line_pulse),
        .peak_in   (peak_hit),
        .fin       (fin),
        .result    (code_nx),
        .load_en   (load_en),
        .load_word (load_word)
    );

    word_serializer #(.WORD_W(WORD_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (line_pulse),
        .load_en    (load_en),
        .load_word  (load_word),
        .step       (adc_tick),
        .ser_data   (ser_data),
        .word_valid (word_valid)
    );
endmodule

// File: rtl/sar_line_sequencer_chk.sv
// Module: sar_line_sequencer_chk
// Port-level temporal checks for sar_line_sequencer, attached by bind.
module sar_line_sequencer_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_pulse,
    input logic              adc_tick,
    input logic [CODE_W-1:0] dac_code,
    input logic              ser_data,
    input logic              word_valid
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    // R2
    mid_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse |=> (dac_code == MID));

    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_pulse && !adc_tick) |=> $stable(dac_code));

    // R3
    step_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_tick && !line_pulse) |=> ($countones(dac_code ^ $past(dac_code)) <= 2));

    // R6
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_pulse |=> !word_valid);

    // R7
    ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_pulse && !adc_tick) |=> $stable(ser_data));
endmodule

bind sar_line_sequencer sar_line_sequencer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_pulse (line_pulse),
    .adc_tick   (adc_tick),
    .dac_code   (dac_code),
    .ser_data   (ser_data),
    .word_valid (word_valid)
);

// File: tb/tb_sar_line_sequencer.sv
// Bench for sar_line_sequencer: a behavioural integer model is compared on
// every cycle, and directed scenarios add explicit checks per requirement.
module tb_sar_line_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_pulse = 1'b0;
    logic       adc_tick = 1'b0;
    logic       peak_hit = 1'b0;
    logic       cmp_ge;
    logic [5:0] dac_code;
    logic       ser_data;
    logic       word_valid;
    int         level = 0;
    int         tests = 0;
    int         fails = 0;
    int         cycles = 0;

    always #5 clk = ~clk;

    // Comparator emulation: held level against the DAC code.
    assign cmp_ge = (level >= int'(dac_code));

    sar_line_sequencer dut (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .adc_tick(adc_tick),
        .cmp_ge(cmp_ge), .peak_hit(peak_hit), .dac_code(dac_code),
        .ser_data(ser_data), .word_valid(word_valid)
    );

    // Behavioural reference model
    int m_code, m_bit, m_run, m_peak, m_pend, m_hold, m_sh, m_left, m_valid;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_bit = 0; m_run = 0; m_peak = 0; m_pend = 0;
            m_hold = 0; m_sh = 0; m_left = 0; m_valid = 0;
        end else if (line_pulse) begin
            m_valid = m_pend;
            m_left  = m_pend ? 7 : 0;
            if (m_pend != 0) m_sh = m_hold;
            m_pend = 0;
            m_peak = int'(peak_hit);
            m_code = 32; m_bit = 5; m_run = 1;
        end else begin
            m_valid = 0;
            if (adc_tick) begin
                if (m_run != 0) begin
                    if (!cmp_ge) m_code = m_code - (1 << m_bit);
                    if (m_bit > 0) begin
                        m_bit  = m_bit - 1;
                        m_code = m_code + (1 << m_bit);
                    end else begin
                        m_run  = 0;
                        m_hold = m_peak * 64 + m_code;
                        m_pend = 1;
                    end
                end
                if (m_left > 0) begin
                    m_left = m_left - 1;
                    m_sh   = (m_sh * 2) % 128;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R3, R6, R7 in every cycle).
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R3", int'(dac_code), m_code, "model dac_code");
            check("R7", int'(ser_data), (m_left > 0) ? ((m_sh >> 6) & 1) : 0, "model ser_data");
            check("R6", int'(word_valid), m_valid, "model word_valid");
        end
    end

    task automatic pulse_line();
        @(negedge clk) line_pulse = 1'b1;
        @(negedge clk) line_pulse = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) adc_tick = 1'b1;
            @(negedge clk) adc_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Collect the 7 serial bits right after a line pulse; the conversion runs alongside.
    task automatic grab_word(output int w);
        w = int'(ser_data);
        for (int i = 0; i < 6; i++) begin
            tick(1);
            w = w * 2 + int'(ser_data);
        end
        tick(1);
        check("R7", int'(ser_data), 0, "ser_data after seventh tick");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        int w;
        repeat (3) @(negedge clk);
        check("R1", int'(dac_code), 0, "dac_code in reset");
        check("R1", int'(ser_data) + int'(word_valid), 0, "serial outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(dac_code), 0, "dac_code after reset");

        // Line A: level 45, peak set
        level = 45; peak_hit = 1'b1;
        pulse_line();
        check("R2", int'(dac_code), 32, "mid-scale start");
        check("R10", int'(word_valid) + int'(ser_data), 0, "no pending word after reset");
        peak_hit = 1'b0;
        tick(6);
        check("R3", int'(dac_code), 45, "result for level 45");
        level = 10;
        tick(3);
        check("R4", int'(dac_code), 45, "result held over extra ticks");

        // Line B: level 0, peak clear; emits word of line A
        level = 0; peak_hit = 1'b0;
        pulse_line();
        check("R6", int'(word_valid), 1, "strobe after line pulse");
        check("R5", int'(ser_data), 1, "first bit is the captured peak");
        grab_word(w);
        check("R7", w, 64 + 45, "word of line A");
        check("R9", int'(dac_code), 0, "black level code");

        // Line C: level 63, peak set; emits word of line B
        level = 63; peak_hit = 1'b1;
        pulse_line();
        grab_word(w);
        check("R7", w, 0, "word of line B");
        check("R9", int'(dac_code), 63, "white level code");

        // Line D: level 20, aborted after 3 ticks; word of C cut off
        level = 20; peak_hit = 1'b0;
        pulse_line();
        check("R6", int'(word_valid), 1, "strobe for line C word");
        tick(3);
        pulse_line();
        check("R8", int'(dac_code), 32, "restart at mid-scale");
        check("R10", int'(ser_data), 0, "cut-off word drives 0");
        check("R8", int'(word_valid), 0, "no word from aborted line");
        tick(6);
        check("R3", int'(dac_code), 20, "result for level 20");

        // Line after the aborted one: emits word of restarted line D
        level = 5;
        pulse_line();
        grab_word(w);
        check("R7", w, 20, "word of restarted line");

        // Pulse after an aborted conversion gives no word
        pulse_line();
        tick(2);
        pulse_line();
        check("R8", int'(word_valid), 0, "nothing pending after abort");
        tick(6);
        check("R3", int'(dac_code), 5, "result for level 5");

        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule